// File: doc/BRIEF.md
# Paged Management-to-Register Bridge

This block sits behind a management-interface slave and turns its 16-bit accesses into 32-bit accesses on an internal register bus. Each management access arrives as a one-cycle strobe carrying a 5-bit device number, a 5-bit register number, a direction flag and 16 bits of write data. The bridge builds an 18-bit byte address from two sources. A 9-bit page register, loaded through a reserved device/register pair, gives the upper bits. Fields folded into the device and register numbers give the lower bits. The lowest bit of the register number picks which 16-bit half of the 32-bit word is meant.

The two halves of a word are joined so that the internal bus only ever sees whole 32-bit accesses. Software writes the upper half first; it is held in the bridge. The following lower-half write then issues one 32-bit bus write. Software reads the lower half first. That issues one 32-bit bus read, returns the low 16 bits and keeps the upper 16 bits for the following upper-half read, which does not touch the bus. Device numbers outside the decoded window are not claimed: reads of them return all ones and writes to them are dropped.

Top module: `mdio_reg_bridge`

## Requirements
- R1: After a synchronous active-low reset, `acc_rdata` is 0, `acc_rvalid` is 0, no bus access is requested, and the page is 0.
- R2: A write to device 0x1F, register 0x10 loads `acc_wdata[8:0]` into the page and does not touch the bus. A read of that pair returns the page zero-extended to 16 bits.
- R3: A bus access uses the byte address {page, dev[2:0], reg[4:1], 2'b00}, so the word address is page in bits [15:7], dev[2:0] in [6:4] and reg[4:1] in [3:0].
- R4: A write to a decoded device with reg[0]=1 (upper half) stores its data in the bridge and issues no bus access.
- R5: A write to a decoded device with reg[0]=0 (lower half) issues exactly one bus write in the same cycle, with data {stored upper half, acc_wdata}.
- R6: A read of a decoded device with reg[0]=0 issues exactly one bus read in the same cycle. It returns bus bits [15:0] and keeps bus bits [31:16].
- R7: A read of a decoded device with reg[0]=1 returns the kept upper half and issues no bus access.
- R8: A device number is decoded only when its bit 4 is 1 and bit 3 is 0. Any other device, apart from the page pair, returns 0xFFFF on a read and ignores a write, with no bus access.
- R9: Every read gives `acc_rvalid` high for one cycle, on the clock edge that samples the strobe. A write never raises `acc_rvalid`.
- R10: The stored write upper half and the kept read upper half are independent. A lower-half read between an upper-half write and its lower-half write changes neither the data of that write nor what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | One-cycle access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_dev | input | 5 | Device number of the access |
| acc_reg | input | 5 | Register number of the access |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data, valid with acc_rvalid |
| acc_rvalid | output | 1 | Read response strobe |
| bus_req | output | 1 | Internal bus access request (combinational) |
| bus_we | output | 1 | Internal bus write enable |
| bus_addr | output | 18 | Internal bus byte address |
| bus_wdata | output | 32 | Internal bus write data |
| bus_rdata | input | 32 | Internal bus read data, sampled in the request cycle |

## Verification
The main stimulus is a sequence of half accesses in the documented order: upper then lower for writes, lower then upper for reads. It is run under three page values, including the all-ones page and a load with stray high data bits. This separates the page bits from the folded device and register fields. The bus model returns data that depends on the address, with different upper and lower halves, so a swapped half or a wrong address shows in the returned data. Undecoded devices are tried with both bit 3 set (including device 0x1F with a register other than 0x10) and bit 4 clear. A read placed between the two halves of a write shows whether the two upper-half stores are kept apart.

// File: rtl/mdio_bridge_pkg.sv
// Shared types for the paged management-to-register bridge.
package mdio_bridge_pkg;

    // Classification of one management access after decode.
    typedef enum logic [2:0] {
        CLS_NONE    = 3'd0,
        CLS_PAGE_WR = 3'd1,
        CLS_PAGE_RD = 3'd2,
        CLS_LO_WR   = 3'd3,
        CLS_HI_WR   = 3'd4,
        CLS_LO_RD   = 3'd5,
        CLS_HI_RD   = 3'd6,
        CLS_MISS    = 3'd7
    } acc_cls_t;

endpackage

// File: rtl/mbr_decode.sv
// Access decoder: sorts a management access into page access, lower or
// upper half access of a decoded device, or an unclaimed access.
// Assumes acc_valid is a single-cycle strobe; purely combinational.
module mbr_decode
    import mdio_bridge_pkg::*;
#(
    parameter int          DEV_W    = 5,
    parameter int          REG_W    = 5,
    parameter logic [4:0]  PAGE_DEV = 5'h1F,
    parameter logic [4:0]  PAGE_REG = 5'h10
) (
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [DEV_W-1:0] acc_dev,
    input  logic [REG_W-1:0] acc_reg,
    output acc_cls_t         cls
);

    logic page_hit;
    logic dev_hit;

    assign page_hit = (acc_dev == DEV_W'(PAGE_DEV)) && (acc_reg == REG_W'(PAGE_REG));
    assign dev_hit  = (acc_dev[DEV_W-1 -: 2] == 2'b10);

    // Purpose: pick the access class from the decode hits and direction.
    always_comb begin
        cls = CLS_NONE;
        if (acc_valid) begin
            if (page_hit)
                cls = acc_write ? CLS_PAGE_WR : CLS_PAGE_RD;
            else if (!dev_hit)
                cls = CLS_MISS;
            else if (acc_reg[0])
                cls = acc_write ? CLS_HI_WR : CLS_HI_RD;
            else
                cls = acc_write ? CLS_LO_WR : CLS_LO_RD;
        end
    end

endmodule

// File: rtl/mbr_page_reg.sv
// Page register: holds the upper word-address bits used by every bus
// access. Loaded only by a page write; cleared by reset.
module mbr_page_reg
    import mdio_bridge_pkg::*;
#(
    parameter int PAGE_W = 9,
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_cls_t          cls,
    input  logic [HALF_W-1:0] acc_wdata,
    output logic [PAGE_W-1:0] page
);

    // Purpose: load the page from the low data bits on a page write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            page <= '0;
        else if (cls == CLS_PAGE_WR)
            page <= acc_wdata[PAGE_W-1:0];
    end

endmodule

// File: rtl/mbr_half_join.sv
// Half joiner: keeps the upper half of a pending 32-bit write and the
// upper half of the last 32-bit read, and registers the 16-bit read
// response. Assumes bus_rdata is valid in the cycle of a lower-half read.
module mbr_half_join
    import mdio_bridge_pkg::*;
#(
    parameter int PAGE_W = 9,
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  acc_cls_t            cls,
    input  logic                rd_strobe,
    input  logic [HALF_W-1:0]   acc_wdata,
    input  logic [2*HALF_W-1:0] bus_rdata,
    input  logic [PAGE_W-1:0]   page,
    output logic [HALF_W-1:0]   wr_hi,
    output logic [HALF_W-1:0]   acc_rdata,
    output logic                acc_rvalid
);

    logic [HALF_W-1:0] rd_hi;

    // Purpose: store the upper half of a write until its lower half arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_hi <= '0;
        else if (cls == CLS_HI_WR)
            wr_hi <= acc_wdata;
    end

    // Purpose: keep the upper half of the last bus read for the next upper read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_hi <= '0;
        else if (cls == CLS_LO_RD)
            rd_hi <= bus_rdata[2*HALF_W-1:HALF_W];
    end

    // Purpose: one-cycle response strobe for every read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_rvalid <= 1'b0;
        else
            acc_rvalid <= rd_strobe;
    end

    // Purpose: select the 16-bit read response by access class.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_rdata <= '0;
        else begin
            case (cls)
                CLS_PAGE_RD: acc_rdata <= {{(HALF_W-PAGE_W){1'b0}}, page};
                CLS_LO_RD:   acc_rdata <= bus_rdata[HALF_W-1:0];
                CLS_HI_RD:   acc_rdata <= rd_hi;
                CLS_MISS:    if (rd_strobe) acc_rdata <= '1;
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/mdio_reg_bridge.sv
// Paged management-to-register bridge top. Maps 16-bit half accesses
// onto whole 32-bit accesses of an internal bus with zero-wait reads.
// Bus request outputs are combinational from the access strobe.
module mdio_reg_bridge
    import mdio_bridge_pkg::*;
#(
    parameter int          DEV_W    = 5,
    parameter int          REG_W    = 5,
    parameter int          PAGE_W   = 9,
    parameter int          HALF_W   = 16,
    parameter logic [4:0]  PAGE_DEV = 5'h1F,
    parameter logic [4:0]  PAGE_REG = 5'h10,
    localparam int         WORD_AW  = PAGE_W + (DEV_W - 2) + (REG_W - 1),
    localparam int         ADDR_W   = WORD_AW + 2,
    localparam int         DATA_W   = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [DEV_W-1:0]  acc_dev,
    input  logic [REG_W-1:0]  acc_reg,
    input  logic [HALF_W-1:0] acc_wdata,
    output logic [HALF_W-1:0] acc_rdata,
    output logic              acc_rvalid,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);

    acc_cls_t          cls;
    logic [PAGE_W-1:0] page;
    logic [HALF_W-1:0] wr_hi;
    logic              rd_strobe;

    assign rd_strobe = acc_valid && !acc_write;

    mbr_decode #(
        .DEV_W(DEV_W), .REG_W(REG_W), .PAGE_DEV(PAGE_DEV), .PAGE_REG(PAGE_REG)
    ) u_decode (
        .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_dev(acc_dev), .acc_reg(acc_reg), .cls(cls)
    );

    mbr_page_reg #(.PAGE_W(PAGE_W), .HALF_W(HALF_W)) u_page (
        .clk(clk), .rst_n(rst_n), .cls(cls), .acc_wdata(acc_wdata), .page(page)
    );

    mbr_half_join #(.PAGE_W(PAGE_W), .HALF_W(HALF_W)) u_join (
        .clk(clk), .rst_n(rst_n), .cls(cls), .rd_strobe(rd_strobe),
        .acc_wdata(acc_wdata), .bus_rdata(bus_rdata), .page(page),
        .wr_hi(wr_hi), .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid)
    );

    // Purpose: drive the internal bus for lower-half accesses only.
    always_comb begin
        bus_req   = (cls == CLS_LO_WR) || (cls == CLS_LO_RD);
        bus_we    = (cls == CLS_LO_WR);
        bus_addr  = {page, acc_dev[DEV_W-3:0], acc_reg[REG_W-1:1], 2'b00};
        bus_wdata = {wr_hi, acc_wdata};
    end

endmodule

// File: rtl/mbr_checker.sv
// Protocol checker for the bridge, bound to every instance of the top.
module mbr_checker #(
    parameter int DEV_W  = 5,
    parameter int REG_W  = 5,
    parameter int PAGE_W = 9,
    parameter int HALF_W = 16,
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [DEV_W-1:0]  acc_dev,
    input logic [REG_W-1:0]  acc_reg,
    input logic [HALF_W-1:0] acc_wdata,
    input logic              acc_rvalid,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr
);

    logic dev_ok;
    logic page_wr;
    assign dev_ok  = (acc_dev[DEV_W-1 -: 2] == 2'b10);
    assign page_wr = acc_valid && acc_write && (acc_dev == '1) &&
                     (acc_reg == REG_W'(5'h10));

    // R8
    miss_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !dev_ok) |-> !bus_req);

    // R4
    upper_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && dev_ok && acc_reg[0]) |-> !bus_req);

    // R5
    we_only_low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> (bus_req && acc_valid && acc_write && !acc_reg[0]));

    // R6
    low_read_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && dev_ok && !acc_reg[0]) |-> (bus_req && !bus_we));

    // R9
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> acc_rvalid);

    // R9
    no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write) |=> !acc_rvalid);

    // R2
    page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_wr |=> (bus_addr[ADDR_W-1 -: PAGE_W] == $past(acc_wdata[PAGE_W-1:0])));

endmodule

bind mdio_reg_bridge mbr_checker #(
    .DEV_W(DEV_W), .REG_W(REG_W), .PAGE_W(PAGE_W), .HALF_W(HALF_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_dev(acc_dev), .acc_reg(acc_reg), .acc_wdata(acc_wdata),
    .acc_rvalid(acc_rvalid), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr)
);

// File: tb/tb_mdio_reg_bridge.sv
module tb_mdio_reg_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [4:0]  acc_dev = '0;
    logic [4:0]  acc_reg = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;
    logic        acc_rvalid;
    logic        bus_req;
    logic        bus_we;
    logic [17:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Captured bus state during the access cycle.
    logic        c_req;
    logic        c_we;
    logic [17:0] c_addr;
    logic [31:0] c_wdata;

    always #10 clk = ~clk;   // 50 MHz

    // Bus model: lower half = word address, upper half = inverted low byte address.
    assign bus_rdata = {~bus_addr[15:0], bus_addr[17:2]};

    mdio_reg_bridge dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_dev(acc_dev), .acc_reg(acc_reg), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic        w;
        logic [4:0]  dev;
        logic [4:0]  rg;
        logic [15:0] wd;
        logic        ereq;
        logic        ewe;
        logic [17:0] eaddr;
        logic [31:0] ewd;
        logic [15:0] erd;
        logic        erv;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{4'd2,  1'b1, 5'h1F, 5'h10, 16'h0003, 1'b0, 1'b0, 18'h0,     32'h0,        16'h0,    1'b0}, // R2 page=3
        '{4'd4,  1'b1, 5'h15, 5'h07, 16'hDEAD, 1'b0, 1'b0, 18'h0,     32'h0,        16'h0,    1'b0}, // R4 upper write
        '{4'd5,  1'b1, 5'h15, 5'h06, 16'hBEEF, 1'b1, 1'b1, 18'h0074C, 32'hDEADBEEF, 16'h0,    1'b0}, // R5 R3
        '{4'd6,  1'b0, 5'h12, 5'h0A, 16'h0000, 1'b1, 1'b0, 18'h00694, 32'h0,        16'h01A5, 1'b1}, // R6 R3
        '{4'd7,  1'b0, 5'h12, 5'h0B, 16'h0000, 1'b0, 1'b0, 18'h0,     32'h0,        16'hF96B, 1'b1}, // R7
        '{4'd8,  1'b0, 5'h05, 5'h00, 16'h0000, 1'b0, 1'b0, 18'h0,     32'h0,        16'hFFFF, 1'b1}, // R8 bit4 clear
        '{4'd8,  1'b1, 5'h08, 5'h10, 16'h1234, 1'b0, 1'b0, 18'h0,     32'h0,        16'h0,    1'b0}, // R8 write dropped
        '{4'd2,  1'b0, 5'h1F, 5'h10, 16'h0000, 1'b0, 1'b0, 18'h0,     32'h0,        16'h0003, 1'b1}, // R2 page read
        '{4'd8,  1'b0, 5'h1F, 5'h11, 16'h0000, 1'b0, 1'b0, 18'h0,     32'h0,        16'hFFFF, 1'b1}, // R8 bit3 set
        '{4'd2,  1'b1, 5'h1F, 5'h10, 16'h01FF, 1'b0, 1'b0, 18'h0,     32'h0,        16'h0,    1'b0}, // R2 page=1FF
        '{4'd3,  1'b0, 5'h17, 5'h1E, 16'h0000, 1'b1, 1'b0, 18'h3FFFC, 32'h0,        16'hFFFF, 1'b1}, // R3 top address
        '{4'd7,  1'b0, 5'h17, 5'h1F, 16'h0000, 1'b0, 1'b0, 18'h0,     32'h0,        16'h0003, 1'b1}, // R7
        '{4'd2,  1'b1, 5'h1F, 5'h10, 16'hFE00, 1'b0, 1'b0, 18'h0,     32'h0,        16'h0,    1'b0}, // R2 stray bits
        '{4'd2,  1'b0, 5'h1F, 5'h10, 16'h0000, 1'b0, 1'b0, 18'h0,     32'h0,        16'h0000, 1'b1}, // R2 page=0
        '{4'd6,  1'b0, 5'h10, 5'h00, 16'h0000, 1'b1, 1'b0, 18'h00000, 32'h0,        16'h0000, 1'b1}  // R6 R3 zero
    };

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive one access for a cycle; capture bus outputs mid-cycle.
    task automatic acc(input logic w, input logic [4:0] d, input logic [4:0] r, input logic [15:0] wd);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_dev = d; acc_reg = r; acc_wdata = wd;
        #1;
        c_req = bus_req; c_we = bus_we; c_addr = bus_addr; c_wdata = bus_wdata;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        string tag;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "rdata", 32'(acc_rdata), 32'h0);
        chk("R1", "rvalid", 32'(acc_rvalid), 32'h0);
        chk("R1", "bus_req", 32'(bus_req), 32'h0);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            tag = $sformatf("R%0d/vec%0d", VEC[i].rq, i);
            acc(VEC[i].w, VEC[i].dev, VEC[i].rg, VEC[i].wd);
            chk(tag, "bus_req", 32'(c_req), 32'(VEC[i].ereq));
            if (VEC[i].ereq) begin
                chk(tag, "bus_addr", 32'(c_addr), 32'(VEC[i].eaddr));
                chk(tag, "bus_we", 32'(c_we), 32'(VEC[i].ewe));
            end
            if (VEC[i].ewe) chk(tag, "bus_wdata", c_wdata, VEC[i].ewd);
            chk(tag, "rvalid", 32'(acc_rvalid), 32'(VEC[i].erv));
            if (VEC[i].erv) chk(tag, "rdata", 32'(acc_rdata), 32'(VEC[i].erd));
        end

        // R10: a read between the halves of a write keeps both stores apart.
        acc(1'b1, 5'h15, 5'h07, 16'h1111);
        acc(1'b0, 5'h10, 5'h00, 16'h0000);
        chk("R10", "mid read low", 32'(acc_rdata), 32'h0000);
        acc(1'b1, 5'h15, 5'h06, 16'h2222);
        chk("R10", "joined wdata", c_wdata, 32'h11112222);
        chk("R10", "joined addr", 32'(c_addr), 32'h0014C);
        acc(1'b0, 5'h10, 5'h01, 16'h0000);
        chk("R10", "read upper kept", 32'(acc_rdata), 32'hFFFF);

        // R1: reset clears the page.
        acc(1'b1, 5'h1F, 5'h10, 16'h00AA);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "rvalid after reset", 32'(acc_rvalid), 32'h0);
        rst_n = 1'b1;
        acc(1'b0, 5'h10, 5'h00, 16'h0000);
        chk("R1", "page cleared addr", 32'(c_addr), 32'h0);

        // R9: write gives no response, read response lasts one cycle.
        acc(1'b0, 5'h05, 5'h00, 16'h0000);
        chk("R9", "rvalid on read", 32'(acc_rvalid), 32'h1);
        @(negedge clk);
        chk("R9", "rvalid one cycle", 32'(acc_rvalid), 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule